// File: doc/BRIEF.md
# Logic Self-Test Sequencer with Count Compaction

This block wraps a small combinational circuit under test so that it can test itself. It normally passes the functional input bus straight through to the circuit. When `start` is seen, it switches the circuit's inputs over to an on-chip linear feedback shift register. It applies a fixed number of pseudo-random patterns, one per clock. It reduces the circuit's one-bit response stream to a small count, which is either the number of ones or the number of value changes.

When the run is over, the count is compared with a golden value held in a two-entry read-only table, with one entry per compaction mode. A mismatch sets `status`. `done` pulses for one cycle while the verdict is already visible, and on the cycle after that the functional inputs are reconnected. Choose the compaction mode per run: each mode misses some faults that the other one catches. The generator polynomial, seed, run length and golden values are all parameters.

Top module: `lbist_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done`=0, `status`=0, `test_sel`=0 and `cut_in` equals `func_in`.
- R2: `test_sel` is 1, and `cut_in` is driven by the generator, from the cycle after the edge that samples `start` up to and including the `done` cycle. In the cycle after `done`, `test_sel`=0 and `cut_in` equals `func_in` again.
- R3: The generator loads `SEED` when a run starts and steps once per cycle with q' = {q[W-2:0], ^(q & TAPS)}. With the defaults (W=3, TAPS=3'b101, SEED=3'b001) the `N_PAT`=7 patterns are 001, 011, 111, 110, 101, 010, 100.
- R4: With `mode`=0 (ones count), the signature is the number of cycles in the run where `cut_out` is 1.
- R5: With `mode`=1 (change count), the signature is the number of adjacent sample pairs in the run whose values differ. The first sample is never counted.
- R6: The signature is compared with golden entry `GOLD_ONES` (mode 0) or `GOLD_EDGES` (mode 1). `status` is 1 when they differ and 0 when they match, so an aliased fault reports 0.
- R7: `done` is a single-cycle pulse in the cycle after the (N_PAT+1)-th rising edge that follows the edge sampling `start`. `status` is already valid in that cycle.
- R8: `status` holds its value while idle and is cleared to 0 from the first run cycle of the next test.
- R9: `start` and `mode` are sampled only while idle. Changing them during a run has no effect on the patterns, the timing or the verdict.
- R10: The signature counter is wide enough for N_PAT, so an all-ones stream counts N_PAT (7 by default) without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a self-test run (sampled while idle) |
| mode | input | 1 | Compaction select: 0 ones count, 1 change count |
| func_in | input | CUT_W | Functional inputs for the circuit under test |
| cut_out | input | 1 | Response bit from the circuit under test |
| cut_in | output | CUT_W | Inputs applied to the circuit under test |
| test_sel | output | 1 | High while the generator drives the circuit |
| done | output | 1 | One-cycle end-of-test pulse |
| status | output | 1 | 1 when the signature differed from golden |

## Verification
Pattern k is due on `cut_in` in the cycle after k+1 rising edges counted from the edge that samples `start`. The bench therefore drives `start` on a falling edge and compares each pattern at the following falling edges. The verdict and the `done` pulse are due one compare cycle after the last pattern, which is N_PAT+1 edges after the start edge. The functional path returns one edge later. The bench samples at exactly those falling edges and also confirms that `done` is low in the cycles around the pulse. The fault table covers streams that alias in one mode but not in the other, and the bench checks the verdict for each.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CMP  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    typedef enum logic {
        CMP_ONES  = 1'b0,
        CMP_EDGES = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic load;   // run begins: reseed, clear counts
        logic step;   // one pattern applied this cycle
        logic first;  // this is the first pattern of the run
    } seq_ctl_t;

    // number of bits needed to hold the value n
    function automatic int unsigned bits_for(input int unsigned n);
        int unsigned b;
        b = 1;
        for (int i = 1; i < 32; i++) begin
            if ((n >> i) != 0) b = i + 1;
        end
        return b;
    endfunction

endpackage

// File: rtl/lbist_seq.sv
module lbist_seq
    import lbist_pkg::*;
#(
    parameter int N_PAT = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mode_i,
    output seq_state_e state_o,
    output cmp_mode_e  mode_o,
    output seq_ctl_t   ctl_o
);
    localparam int unsigned IDX_W = bits_for(N_PAT);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_PAT - 1);

    seq_state_e       state_q;
    cmp_mode_e        mode_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= CMP_ONES;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        mode_q  <= cmp_mode_e'(mode_i);
                        idx_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (idx_q == LAST_IDX) state_q <= ST_CMP;
                    else                   idx_q   <= idx_q + 1'b1;
                end
                ST_CMP:  state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.load  = (state_q == ST_IDLE) && start;
        ctl_o.step  = (state_q == ST_RUN);
        ctl_o.first = (idx_q == '0);
    end

    assign state_o = state_q;
    assign mode_o  = mode_q;

endmodule

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
    parameter int              W     = 3,
    parameter logic [W-1:0]    TAPS  = 3'b101,
    parameter logic [W-1:0]    SEED  = 3'b001
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] pat_o
);
    logic [W-1:0] q;
    logic [W-1:0] nxt;
    logic         fb;

    always_comb begin
        fb  = ^(q & TAPS);
        nxt = {q[W-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst || load) q <= SEED;
        else if (step)   q <= nxt;
    end

    assign pat_o = q;

endmodule

// File: rtl/lbist_compactor.sv
module lbist_compactor
    import lbist_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_ctl_t         ctl,
    input  cmp_mode_e        mode,
    input  logic             bit_i,
    output logic [CNT_W-1:0] sig_o
);
    logic [CNT_W-1:0] sig_q;
    logic             prev_q;
    logic             inc;

    always_comb begin
        unique case (mode)
            CMP_ONES:  inc = bit_i;
            CMP_EDGES: inc = !ctl.first && (bit_i != prev_q);
            default:   inc = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.load) begin
            sig_q  <= '0;
            prev_q <= 1'b0;
        end else if (ctl.step) begin
            sig_q  <= sig_q + CNT_W'(inc);
            prev_q <= bit_i;
        end
    end

    assign sig_o = sig_q;

endmodule

// File: rtl/lbist_top.sv
module lbist_top
    import lbist_pkg::*;
#(
    parameter int               CUT_W      = 3,
    parameter logic [CUT_W-1:0] TAPS       = 3'b101,
    parameter logic [CUT_W-1:0] SEED       = 3'b001,
    parameter int               N_PAT      = (1 << CUT_W) - 1,
    parameter int               GOLD_ONES  = 1,
    parameter int               GOLD_EDGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode,
    input  logic [CUT_W-1:0] func_in,
    input  logic             cut_out,
    output logic [CUT_W-1:0] cut_in,
    output logic             test_sel,
    output logic             done,
    output logic             status
);
    localparam int unsigned CNT_W = bits_for(N_PAT);

    // golden signature store, indexed by compaction mode
    localparam logic [CNT_W-1:0] GOLD_TBL [2] = '{CNT_W'(GOLD_ONES), CNT_W'(GOLD_EDGES)};

    seq_state_e       state;
    cmp_mode_e        mode_q;
    seq_ctl_t         ctl;
    logic [CUT_W-1:0] pat;
    logic [CNT_W-1:0] sig_val;
    logic [CNT_W-1:0] gold_val;
    logic             status_q;
    logic             run_phase;

    lbist_seq #(.N_PAT(N_PAT)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mode_i  (mode),
        .state_o (state),
        .mode_o  (mode_q),
        .ctl_o   (ctl)
    );

    lbist_prpg #(.W(CUT_W), .TAPS(TAPS), .SEED(SEED)) u_prpg (
        .clk   (clk),
        .rst   (rst),
        .load  (ctl.load),
        .step  (ctl.step),
        .pat_o (pat)
    );

    lbist_compactor #(.CNT_W(CNT_W)) u_cmp (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .mode  (mode_q),
        .bit_i (cut_out),
        .sig_o (sig_val)
    );

    assign gold_val = GOLD_TBL[mode_q];

    always_ff @(posedge clk) begin
        if (rst || ctl.load)     status_q <= 1'b0;
        else if (state == ST_CMP) status_q <= (sig_val != gold_val);
    end

    assign run_phase = (state == ST_RUN);
    assign test_sel  = (state != ST_IDLE);
    assign cut_in    = test_sel ? pat : func_in;
    assign done      = (state == ST_DONE);
    assign status    = status_q;

endmodule

// File: rtl/lbist_chk.sv
module lbist_chk #(
    parameter int CUT_W = 3,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             test_sel,
    input logic             done,
    input logic             status,
    input logic [CUT_W-1:0] cut_in,
    input logic             run_i,
    input logic [CNT_W-1:0] sig_i
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    return_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(test_sel) |-> $past(done));

    // R3
    pattern_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        test_sel |-> (cut_in != '0));

    // R8
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!test_sel && !start) |=> $stable(status));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (test_sel && !done && start) |=> test_sel);

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && $past(run_i)) |-> (sig_i >= $past(sig_i)));

endmodule

bind lbist_top lbist_chk #(.CUT_W(CUT_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .test_sel (test_sel),
    .done     (done),
    .status   (status),
    .cut_in   (cut_in),
    .run_i    (run_phase),
    .sig_i    (sig_val)
);

// File: tb/lbist_top_bench.sv
`timescale 1ns/1ps
module lbist_top_bench;
    localparam int         W      = 3;
    localparam int         NP     = 7;
    localparam logic [2:0] BTAPS  = 3'b101;
    localparam logic [2:0] BSEED  = 3'b001;

    // vector: {fault[2:0], mode, expected status}
    // fault 0 good 0001000 (ones 1, changes 2); 1 -> 0001100 (2,2);
    // 2 -> 1000000 (1,1); 3 -> stuck 0 (0,0); 4 -> stuck 1 (7,0)
    localparam int NV = 10;
    localparam logic [4:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b0},   // R4 good, ones
        {3'd0, 1'b1, 1'b0},   // R5 good, changes
        {3'd1, 1'b0, 1'b1},   // R4 detected by ones
        {3'd1, 1'b1, 1'b0},   // R5 aliased by changes
        {3'd2, 1'b0, 1'b0},   // R4 aliased by ones
        {3'd2, 1'b1, 1'b1},   // R5 detected by changes
        {3'd3, 1'b0, 1'b1},   // R6 stuck low
        {3'd3, 1'b1, 1'b1},   // R6 stuck low
        {3'd4, 1'b0, 1'b1},   // R10 count reaches 7
        {3'd4, 1'b1, 1'b1}    // R5 no changes
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic         mode;
    logic [W-1:0] func_in;
    logic         cut_out;
    logic [W-1:0] cut_in;
    logic         test_sel;
    logic         done;
    logic         status;
    int           fault_sel;
    int           n_tests = 0;
    int           n_fail  = 0;

    always #2.5 clk = ~clk;

    lbist_top u_lbist_top (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode     (mode),
        .func_in  (func_in),
        .cut_out  (cut_out),
        .cut_in   (cut_in),
        .test_sel (test_sel),
        .done     (done),
        .status   (status)
    );

    // stand-in circuit under test with selectable faults
    always_comb begin
        case (fault_sel)
            1:       cut_out = (cut_in == 3'b110) || (cut_in == 3'b101);
            2:       cut_out = (cut_in == 3'b001);
            3:       cut_out = 1'b0;
            4:       cut_out = 1'b1;
            default: cut_out = (cut_in == 3'b110);
        endcase
    end

    function automatic logic [2:0] model_next(input logic [2:0] q);
        return {q[1:0], ^(q & BTAPS)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_one(input int flt, input logic md, input logic exp_st, input bit poke);
        logic [2:0] q;
        string rq;
        rq = md ? "R5" : "R4";
        fault_sel = flt;
        mode      = md;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        q = BSEED;
        for (int k = 0; k < NP; k++) begin
            chk(cut_in == q, "R3", int'(cut_in), int'(q));
            chk(test_sel == 1'b1, "R2", int'(test_sel), 1);
            chk(done == 1'b0, "R7", int'(done), 0);
            if (k == 0) chk(status == 1'b0, "R8", int'(status), 0);
            if (poke && k == 2) begin
                start = 1'b1;      // R9 stray start and mode mid-run
                mode  = ~md;
            end else begin
                start = 1'b0;
            end
            q = model_next(q);
            @(negedge clk);
        end
        chk(done == 1'b0, "R7", int'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R7", int'(done), 1);
        chk(status == exp_st, poke ? "R9" : rq, int'(status), int'(exp_st));
        chk(status == exp_st, "R6", int'(status), int'(exp_st));
        chk(test_sel == 1'b1, "R2", int'(test_sel), 1);
        @(negedge clk);
        chk(done == 1'b0, "R7", int'(done), 0);
        chk(test_sel == 1'b0, "R2", int'(test_sel), 0);
        chk(cut_in == func_in, "R2", int'(cut_in), int'(func_in));
        chk(status == exp_st, "R8", int'(status), int'(exp_st));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; mode = 1'b0; func_in = 3'b101; fault_sel = 0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(done == 1'b0 && status == 1'b0, "R1", int'({done, status}), 0);
        chk(test_sel == 1'b0, "R1", int'(test_sel), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(test_sel == 1'b0 && done == 1'b0, "R1", int'({test_sel, done}), 0);
        chk(cut_in == func_in, "R1", int'(cut_in), int'(func_in));
        chk(status == 1'b0, "R1", int'(status), 0);

        for (int v = 0; v < NV; v++) begin
            func_in = 3'(v);
            run_one(int'(VEC[v][4:2]), VEC[v][1], VEC[v][0], 1'b0);
            repeat (2) @(negedge clk);
        end

        // R9: fault 2 in change mode fails; stray start and mode flip mid-run ignored
        run_one(2, 1'b1, 1'b1, 1'b1);
        // R8: verdict held through idle cycles with changing functional inputs
        for (int i = 0; i < 5; i++) begin
            func_in = 3'(i + 2);
            @(negedge clk);
            chk(status == 1'b1, "R8", int'(status), 1);
            chk(cut_in == func_in, "R2", int'(cut_in), int'(func_in));
        end
        // R8: next run clears status in its first cycle (checked in run_one), good circuit passes
        run_one(0, 1'b1, 1'b0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule